// File: doc/BRIEF.md
# Reference Pulse Phase Capture Front End

This block sits between an asynchronous once-per-second reference pulse and the local oscillator clock of a disciplined frequency source. A free-running divider counts oscillator cycles and marks each local second with a one-cycle pulse. Each of two capture channels brings an asynchronous reference edge into the clock domain. The first synchronizer flop of each channel samples on the falling clock edge, because a locked loop puts the reference edge close to the rising edge. On each detected edge the channel latches the low bits of the divider, so software gets a coarse timestamp that does not depend on when it polls.

Each channel also drives a start and a stop pulse for an external fine interval converter, and the two pulses are always a fixed number of clock cycles apart. A one-bit early/late phase flag gives a cheap alternative measure of phase. Channel 0 always watches the reference pulse. Channel 1 watches either a separate event input or the same reference pulse, chosen by a select input, so two measurement paths can be compared on one edge.

Top module: `pps_phase_front`

## Requirements
- R1: The divider counts 0 to DIV_MOD-1 and wraps to 0. `loc_sec` is high for exactly the one cycle in which the count is 0 after a wrap, so the first pulse comes DIV_MOD cycles after reset is released and none comes during reset.
- R2: A reference rise is captured when it is sampled on a falling clock edge. `cap_ts` then holds the low LATCH_W bits of the divider value present after the next rising edge. Channel c uses bits [c*LATCH_W +: LATCH_W]. The result appears one rising edge later.
- R3: `tdc_start[c]` is a one-cycle pulse and is high in the same cycle that a new capture is visible on `cap_valid[c]` and `cap_ts`.
- R4: `tdc_stop[c]` is a one-cycle pulse that comes exactly STOP_GAP cycles after `tdc_start[c]`, and at no other time.
- R5: A reference rise that arrives while a stop is still pending is captured, but it produces no `tdc_start` and does not move the pending stop.
- R6: A capture while `cap_valid[c]` is set and no read is given sets `cap_ovr[c]`. A capture in the same cycle as `rd_ack[c]` leaves `cap_valid[c]` set and `cap_ovr[c]` clear.
- R7: `rd_ack[c]` with no capture clears `cap_valid[c]` and `cap_ovr[c]` on the next rising edge.
- R8: `pd_lead[c]` is 1 when the captured divider value is at least DIV_MOD/2 (the reference is ahead of the next local second), and 0 otherwise. It holds until the next capture.
- R9: Channel 0 takes `pps_in`. Channel 1 takes `pps_in` when `ch1_use_pps` is 1 and `evt_in` when it is 0. A channel never reacts to the input it is not routed to.
- R10: While `rst` is high every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous reference pulse |
| evt_in | input | 1 | Asynchronous auxiliary event input |
| ch1_use_pps | input | 1 | 1: channel 1 watches pps_in, 0: evt_in |
| rd_ack | input | 2 | Per-channel read acknowledge |
| loc_sec | output | 1 | One-cycle local second mark |
| cap_ts | output | 2*LATCH_W | Latched low divider bits, channel c at [c*LATCH_W +: LATCH_W] |
| cap_valid | output | 2 | Capture not yet read |
| cap_ovr | output | 2 | Capture overwritten before read |
| tdc_start | output | 2 | Start pulse for the fine converter |
| tdc_stop | output | 2 | Stop pulse for the fine converter |
| pd_lead | output | 2 | One-bit early/late phase flag |

## Verification
Single reference edges are aimed at divider values 499, 500, 999 and 0 (with DIV_MOD=1000). These separate a wrong early/late threshold and any off-by-one in the capture latency. A double edge inside the stop window tells apart a design that lets start pulses through while a stop is pending. Reads placed before, during and after a capture tell apart the valid and overrun rules. Random gaps, source selections and read patterns mix both channels, so any crosstalk between the two channels or a wrong source mux setting shows up.

// File: rtl/pps_cap_pkg.sv
package pps_cap_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic {
    SRC_EVT = 1'b0,
    SRC_PPS = 1'b1
  } ch1_src_e;

  function automatic int width_for(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/pps_divider.sv
module pps_divider #(
  parameter int DIV_W   = 24,
  parameter int DIV_MOD = 10_000_000
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] count,
  output logic             sec_tick
);

  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_MOD - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count    = cnt_q;
  assign sec_tick = tick_q;

endmodule

// File: rtl/pps_sync_edge.sv
module pps_sync_edge #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  localparam int NS = (STAGES < 3) ? 3 : STAGES;

  logic          fall_q;
  logic [NS-1:1] tail_q;

  // First stage on the falling edge: a locked reference lands near the rising edge.
  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= async_in;
  end

  always_ff @(posedge clk) begin
    if (rst) tail_q <= '0;
    else     tail_q <= {tail_q[NS-2:1], fall_q};
  end

  assign rise = tail_q[NS-2] & ~tail_q[NS-1];

endmodule

// File: rtl/pps_chan.sv
module pps_chan #(
  parameter int DIV_W       = 24,
  parameter int DIV_MOD     = 10_000_000,
  parameter int LATCH_W     = 8,
  parameter int SYNC_STAGES = 3,
  parameter int STOP_GAP    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_in,
  input  logic [DIV_W-1:0]   count,
  input  logic               rd_ack,
  output logic [LATCH_W-1:0] ts,
  output logic               valid,
  output logic               ovr,
  output logic               start,
  output logic               stop,
  output logic               lead
);

  localparam int               GAP_W  = pps_cap_pkg::width_for(STOP_GAP);
  localparam logic [DIV_W-1:0] HALF_V = DIV_W'(DIV_MOD / 2);
  localparam logic [GAP_W-1:0] GAP_V  = GAP_W'(STOP_GAP);

  logic               rise;
  logic [GAP_W-1:0]   gap_q;
  logic               busy;
  logic [LATCH_W-1:0] ts_q;
  logic               valid_q, ovr_q, start_q, stop_q, lead_q;

  pps_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ref_in),
    .rise     (rise)
  );

  assign busy = (gap_q != '0);

  // Start/stop pair for the fine converter, spaced STOP_GAP cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= rise & ~busy;
      stop_q  <= busy && (gap_q == GAP_W'(1));
      if (rise && !busy) gap_q <= GAP_V;
      else if (busy)     gap_q <= gap_q - 1'b1;
    end
  end

  // Coarse timestamp, flags and early/late phase bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      lead_q  <= 1'b0;
    end else if (rise) begin
      ts_q    <= count[LATCH_W-1:0];
      valid_q <= 1'b1;
      ovr_q   <= rd_ack ? 1'b0 : (ovr_q | valid_q);
      lead_q  <= (count >= HALF_V);
    end else if (rd_ack) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign ts    = ts_q;
  assign valid = valid_q;
  assign ovr   = ovr_q;
  assign start = start_q;
  assign stop  = stop_q;
  assign lead  = lead_q;

endmodule

// File: rtl/pps_phase_front.sv
module pps_phase_front #(
  parameter int DIV_W       = 24,
  parameter int DIV_MOD     = 10_000_000,
  parameter int LATCH_W     = 8,
  parameter int SYNC_STAGES = 3,
  parameter int STOP_GAP    = 1
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       pps_in,
  input  logic                                       evt_in,
  input  logic                                       ch1_use_pps,
  input  logic [pps_cap_pkg::NUM_CH-1:0]             rd_ack,
  output logic                                       loc_sec,
  output logic [pps_cap_pkg::NUM_CH*LATCH_W-1:0]     cap_ts,
  output logic [pps_cap_pkg::NUM_CH-1:0]             cap_valid,
  output logic [pps_cap_pkg::NUM_CH-1:0]             cap_ovr,
  output logic [pps_cap_pkg::NUM_CH-1:0]             tdc_start,
  output logic [pps_cap_pkg::NUM_CH-1:0]             tdc_stop,
  output logic [pps_cap_pkg::NUM_CH-1:0]             pd_lead
);

  import pps_cap_pkg::*;

  logic [DIV_W-1:0]  count;
  logic [NUM_CH-1:0] ref_vec;
  ch1_src_e          ch1_src;

  pps_divider #(.DIV_W(DIV_W), .DIV_MOD(DIV_MOD)) u_div (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .sec_tick (loc_sec)
  );

  assign ch1_src    = ch1_src_e'(ch1_use_pps);
  assign ref_vec[0] = pps_in;
  assign ref_vec[1] = (ch1_src == SRC_PPS) ? pps_in : evt_in;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pps_chan #(
      .DIV_W       (DIV_W),
      .DIV_MOD     (DIV_MOD),
      .LATCH_W     (LATCH_W),
      .SYNC_STAGES (SYNC_STAGES),
      .STOP_GAP    (STOP_GAP)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .ref_in (ref_vec[c]),
      .count  (count),
      .rd_ack (rd_ack[c]),
      .ts     (cap_ts[c*LATCH_W +: LATCH_W]),
      .valid  (cap_valid[c]),
      .ovr    (cap_ovr[c]),
      .start  (tdc_start[c]),
      .stop   (tdc_stop[c]),
      .lead   (pd_lead[c])
    );
  end

endmodule

// File: rtl/pps_phase_front_chk.sv
module pps_phase_front_chk #(
  parameter int STOP_GAP = 1,
  parameter int NCH      = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] rd_ack,
  input logic           loc_sec,
  input logic [NCH-1:0] cap_valid,
  input logic [NCH-1:0] cap_ovr,
  input logic [NCH-1:0] tdc_start,
  input logic [NCH-1:0] tdc_stop
);

  localparam int SW = pps_cap_pkg::width_for(STOP_GAP + 2);

  p_sec_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    loc_sec |=> !loc_sec);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic          armed;
    logic [SW-1:0] since;

    always_ff @(posedge clk) begin
      if (rst) begin
        armed <= 1'b0;
        since <= '0;
      end else if (tdc_start[c]) begin
        armed <= 1'b1;
        since <= SW'(1);
      end else if (tdc_stop[c]) begin
        armed <= 1'b0;
      end else if (armed && since <= SW'(STOP_GAP)) begin
        since <= since + 1'b1;
      end
    end

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      tdc_start[c] |=> !tdc_start[c]);

    p_start_valid_r3: assert property (@(posedge clk) disable iff (rst)
      tdc_start[c] |-> cap_valid[c]);

    p_stop_spacing_r4: assert property (@(posedge clk) disable iff (rst)
      tdc_stop[c] |-> (armed && since == SW'(STOP_GAP)));

    p_ovr_rise_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_ovr[c]) |-> $past(cap_valid[c]));

    p_valid_clear_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(cap_valid[c]) |-> $past(rd_ack[c]));
  end

endmodule

bind pps_phase_front pps_phase_front_chk #(
  .STOP_GAP (STOP_GAP),
  .NCH      (pps_cap_pkg::NUM_CH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_ack    (rd_ack),
  .loc_sec   (loc_sec),
  .cap_valid (cap_valid),
  .cap_ovr   (cap_ovr),
  .tdc_start (tdc_start),
  .tdc_stop  (tdc_stop)
);

// File: tb/tb_pps_phase_front.sv
module tb_pps_phase_front;

  localparam int MOD = 1000;
  localparam int LW  = 8;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pps_in = 1'b0, evt_in = 1'b0, ch1_use_pps = 1'b0;
  logic [1:0] rd_ack = 2'b00;
  logic       loc_sec;
  logic [2*LW-1:0] cap_ts;
  logic [1:0] cap_valid, cap_ovr, tdc_start, tdc_stop, pd_lead;

  int checks = 0, errors = 0;
  bit done = 0;
  int mcnt = 0;
  bit mwrap = 0;

  always #4 clk = ~clk;

  pps_phase_front #(
    .DIV_W(24), .DIV_MOD(MOD), .LATCH_W(LW), .SYNC_STAGES(3), .STOP_GAP(GAP)
  ) dut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .evt_in(evt_in),
    .ch1_use_pps(ch1_use_pps), .rd_ack(rd_ack), .loc_sec(loc_sec),
    .cap_ts(cap_ts), .cap_valid(cap_valid), .cap_ovr(cap_ovr),
    .tdc_start(tdc_start), .tdc_stop(tdc_stop), .pd_lead(pd_lead)
  );

  // Divider model from R1
  always @(posedge clk) begin
    if (rst) begin mcnt <= 0; mwrap <= 0; end
    else if (mcnt == MOD-1) begin mcnt <= 0; mwrap <= 1; end
    else mcnt <= mcnt + 1;
  end

  function automatic int exp_lead(input int v);
    return (v >= MOD/2) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ts_of(input int c);
    return int'(cap_ts[c*LW +: LW]);
  endfunction

  // One reference pulse on pps (src=0) or evt (src=1); mask = channels expected to capture.
  task automatic pulse(input int src, input logic [1:0] mask, input bit rd_at_cap);
    int e;
    logic [1:0] pv, po;
    @(posedge clk); #1;
    if (src == 0) pps_in = 1'b1; else evt_in = 1'b1;
    pv = cap_valid; po = cap_ovr;
    @(posedge clk); #1;
    e = mcnt;
    if (rd_at_cap) rd_ack = mask;
    @(posedge clk); #1;
    rd_ack = 2'b00;
    pps_in = 1'b0; evt_in = 1'b0;
    for (int c = 0; c < 2; c++) begin
      if (mask[c]) begin
        check(tdc_start[c] == 1'b1, "R3 start", tdc_start[c], 1);
        check(cap_valid[c] == 1'b1, "R3 valid", cap_valid[c], 1);
        check(ts_of(c) == (e % (1 << LW)), "R2 timestamp", ts_of(c), e % (1 << LW));
        check(int'(pd_lead[c]) == exp_lead(e), "R8 lead", pd_lead[c], exp_lead(e));
        if (rd_at_cap)
          check(cap_ovr[c] == 1'b0, "R6 read at capture", cap_ovr[c], 0);
        else
          check(cap_ovr[c] == (pv[c] | po[c]), "R6 overrun", cap_ovr[c], pv[c] | po[c]);
      end else begin
        check(tdc_start[c] == 1'b0, "R9 no start", tdc_start[c], 0);
        check(cap_valid[c] == pv[c], "R9 valid untouched", cap_valid[c], pv[c]);
      end
    end
    for (int k = 1; k < GAP; k++) begin
      @(posedge clk); #1;
      check(tdc_stop == 2'b00, "R4 early stop", tdc_stop, 0);
      check(tdc_start == 2'b00, "R3 start width", tdc_start, 0);
    end
    @(posedge clk); #1;
    check(tdc_stop == mask, "R4 stop", tdc_stop, mask);
    @(posedge clk); #1;
    check(tdc_stop == 2'b00, "R4 stop width", tdc_stop, 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic do_read(input logic [1:0] m);
    @(posedge clk); #1;
    rd_ack = m;
    @(posedge clk); #1;
    rd_ack = 2'b00;
    check((cap_valid & m) == 2'b00, "R7 valid cleared", cap_valid & m, 0);
    check((cap_ovr & m) == 2'b00, "R7 ovr cleared", cap_ovr & m, 0);
  endtask

  task automatic aim(input int target);
    int pre;
    pre = (target - 2 + MOD) % MOD;
    @(posedge clk); #1;
    while (mcnt != pre) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e2;
    logic [1:0] m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check({loc_sec, cap_ts, cap_valid, cap_ovr, tdc_start, tdc_stop, pd_lead} == '0,
          "R10 reset outputs", 0, 0);
    pps_in = 1'b1;
    repeat (3) @(posedge clk); #1;
    check({cap_valid, tdc_start} == '0, "R10 pulse ignored in reset", {cap_valid, tdc_start}, 0);
    pps_in = 1'b0;
    repeat (2) @(posedge clk);
    @(posedge clk); #1 rst = 1'b0;

    // R1 local second over two wraps
    for (int k = 0; k < 2 * MOD + 50; k++) begin
      check(loc_sec == (mcnt == 0 && mwrap), "R1 local second", loc_sec, (mcnt == 0 && mwrap));
      @(posedge clk); #1;
    end

    // R8 thresholds and wrap corners, channel 0 only
    ch1_use_pps = 1'b0;
    aim(499); pulse(0, 2'b01, 0); do_read(2'b01);
    aim(500); pulse(0, 2'b01, 0); do_read(2'b01);
    aim(999); pulse(0, 2'b01, 0); do_read(2'b01);
    aim(0);   pulse(0, 2'b01, 0); do_read(2'b01);

    // R9 source select
    pulse(1, 2'b10, 0); do_read(2'b10);
    ch1_use_pps = 1'b1;
    pulse(1, 2'b00, 0);
    pulse(0, 2'b11, 0); do_read(2'b11);

    // R6 overrun, then read in the capture cycle
    pulse(0, 2'b11, 0);
    pulse(0, 2'b11, 0);
    pulse(0, 2'b11, 1);
    check(cap_valid == 2'b11, "R6 valid kept", cap_valid, 3);
    do_read(2'b11);

    // R5 second edge while stop pending
    ch1_use_pps = 1'b0;
    @(posedge clk); #1 pps_in = 1'b1;
    @(posedge clk); #1 pps_in = 1'b0;
    @(posedge clk); #1 pps_in = 1'b1;
    check(tdc_start[0] == 1'b1, "R5 first start", tdc_start[0], 1);
    @(posedge clk); #1 e2 = mcnt;
    @(posedge clk); #1 pps_in = 1'b0;
    check(tdc_start[0] == 1'b0, "R5 suppressed start", tdc_start[0], 0);
    check(ts_of(0) == e2 % (1 << LW), "R5 second capture", ts_of(0), e2 % (1 << LW));
    check(cap_ovr[0] == 1'b1, "R5 overrun", cap_ovr[0], 1);
    @(posedge clk); #1;
    check(tdc_stop[0] == 1'b1, "R5 stop unchanged", tdc_stop[0], 1);
    @(posedge clk); #1;
    check(tdc_stop[0] == 1'b0, "R5 single stop", tdc_stop[0], 0);
    repeat (4) @(posedge clk);
    do_read(2'b11);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int src;
      bit sel;
      repeat ($urandom_range(2, 1800)) @(posedge clk);
      #1;
      sel = 1'($urandom_range(0, 1));
      src = int'($urandom_range(0, 1));
      ch1_use_pps = sel;
      if (src == 0) m = sel ? 2'b11 : 2'b01;
      else          m = sel ? 2'b00 : 2'b10;
      pulse(src, m, 0);
      if ($urandom_range(0, 2) != 0) do_read(2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule